// File: doc/BRIEF.md
# Serial keyboard protocol responder

This block is the device half of a serial keyboard link. Key events arrive as a 7-bit key code with a down flag. They are turned into make or break bytes and queued for the host. Two lock keys (caps and num) pass through a small toggle filter, so a latching key reports one press and one release per full latch cycle. Command bytes from the host's transmit path are decoded. A keyboard-reset command and a layout query each discard whatever is queued and load a fixed reply. A set-indicators command swallows the byte that follows it.

The host drains the queue through a read port. `rd_valid` is high while at least one byte is held. `rd_data` shows the oldest byte, and `rd_en` removes it. The queue is a flat buffer of parameterised depth, 256 bytes by default. A multi-byte reply is loaded into it in a single cycle.

Top module: `kbd_responder`

## Requirements
- R1: A key event with the down flag set enqueues `{1'b0, code}`. A key event with the down flag clear enqueues `{1'b1, code}`. Bit 7 is the release marker.
- R2: Each lock key keeps a 2-bit state that starts at 0. A press XORs the state with 1 and is dropped if the result is 2. A release XORs the state with 2 and is dropped if the result is 3. Starting from 0, the sequence press, release, press, release therefore emits only the first press and the last release.
- R3: The caps-lock code (default 0x77) and the num-lock code (default 0x62) have separate states. An event on one never changes the filtering of the other. All other codes are never filtered.
- R4: Host command 0x01 empties the queue and leaves exactly 0xFF, 0x04, 0x7F in it, in that order. These bytes are readable from the next cycle.
- R5: Host command 0x0E arms an indicator flag. The next command byte, whatever its value, is consumed with no effect and clears the flag.
- R6: Host commands 0x07 and 0x0F each empty the queue and leave exactly 0xFE, 0x21 in it, in that order.
- R7: Any other command byte leaves the queue contents unchanged.
- R8: The queue holds DEPTH bytes. A byte offered while DEPTH bytes are held is discarded, and the held bytes are kept in order.
- R9: While the queue is empty, `rd_valid` is 0 and `rd_data` is 0, and `rd_en` has no effect. While the queue is not empty, `rd_data` is the oldest byte and `rd_en` removes it.
- R10: Reset (rst_n low at a clock edge) empties the queue, returns both lock states to 0 and disarms the indicator flag.
- R11: A key byte accepted in the same cycle as a reply-loading command is queued directly after that reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 7 | Key code of the event |
| key_down | input | 1 | 1 = press, 0 = release |
| cmd_valid | input | 1 | Host command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| rd_en | input | 1 | Remove the oldest queued byte |
| rd_data | output | 8 | Oldest queued byte, 0 when empty |
| rd_valid | output | 1 | Queue holds at least one byte |

## Verification
The bench walks every non-lock key code in both directions and fills the queue to capacity and one byte past it. A design that dropped the release marker, lost ordering at the pointer wrap, or let an extra byte overwrite the head would show a mismatch on drain. It also sweeps every command value that must be ignored. A decoder that matched too loosely would flush the single byte the bench had queued beforehand. The lock sequences, an armed indicator flag followed by a reset command, and a key event landing in the same cycle as a layout query are each checked separately. A filter that compared the wrong state value, a flag that never cleared, or a flush that discarded the simultaneous key would each leave the wrong bytes in the queue.

// File: rtl/kbd_resp_pkg.sv
// Shared widths, command codes and reply descriptor for the keyboard responder.
package kbd_resp_pkg;
    localparam int BYTE_W    = 8;
    localparam int CODE_W    = BYTE_W - 1;
    localparam int REPLY_MAX = 3;
    localparam int LEN_W     = $clog2(REPLY_MAX + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CMD_KBD_RESET = 8'h01;
    localparam byte_t CMD_LAYOUT_LO = 8'h07;
    localparam byte_t CMD_INDICATOR = 8'h0E;
    localparam byte_t CMD_LAYOUT_HI = 8'h0F;

    // Reply loaded into the queue after a flush.
    typedef struct packed {
        logic                        flush;
        logic [LEN_W-1:0]            len;
        logic [REPLY_MAX-1:0][BYTE_W-1:0] bytes;
    } reply_t;
endpackage

// File: rtl/kbd_lock_filter.sv
// Two-bit toggle filter for one latching key.
// Assumes: at most one key event per cycle; events for other codes pass.
module kbd_lock_filter
    import kbd_resp_pkg::*;
#(
    parameter logic [CODE_W-1:0] LOCK_CODE = 7'h77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              ev_down,
    output logic              ev_pass
);
    logic [1:0] state_q;
    logic [1:0] state_nxt;
    logic       hit;
    logic       drop;

    // Next toggle state and drop decision for this event.
    always_comb begin
        hit       = ev_valid && (ev_code == LOCK_CODE);
        state_nxt = ev_down ? (state_q ^ 2'b01) : (state_q ^ 2'b10);
        drop      = hit && (ev_down ? (state_nxt == 2'b10) : (state_nxt == 2'b11));
        ev_pass   = !drop;
    end

    // Toggle state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= 2'b00;
        end else if (hit) begin
            state_q <= state_nxt;
        end
    end
endmodule

// File: rtl/kbd_cmd_decoder.sv
// Decodes host command bytes into queue reply loads.
// Assumes: one command byte per cycle; the indicator byte is never decoded.
module kbd_cmd_decoder
    import kbd_resp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_valid,
    input  byte_t  cmd_byte,
    output reply_t reply,
    output logic   led_armed
);
    logic armed_q;

    assign led_armed = armed_q;

    // Select the reply for an active, non-swallowed command.
    always_comb begin
        reply = '0;
        if (cmd_valid && !armed_q) begin
            unique case (cmd_byte)
                CMD_KBD_RESET: begin
                    reply.flush    = 1'b1;
                    reply.len      = LEN_W'(3);
                    reply.bytes[0] = 8'hFF;
                    reply.bytes[1] = 8'h04;
                    reply.bytes[2] = 8'h7F;
                end
                CMD_LAYOUT_LO, CMD_LAYOUT_HI: begin
                    reply.flush    = 1'b1;
                    reply.len      = LEN_W'(2);
                    reply.bytes[0] = 8'hFE;
                    reply.bytes[1] = 8'h21;
                end
                default: reply = '0;
            endcase
        end
    end

    // Indicator flag: armed by its command, cleared by the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (cmd_valid) begin
            armed_q <= !armed_q && (cmd_byte == CMD_INDICATOR);
        end
    end
endmodule

// File: rtl/kbd_byte_fifo.sv
// Byte queue with single-byte push, pop, and a one-cycle flush-and-load.
// Assumes: DEPTH is a power of two and larger than REPLY_MAX.
module kbd_byte_fifo
    import kbd_resp_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [LEN_W-1:0]                 load_len,
    input  logic [REPLY_MAX-1:0][BYTE_W-1:0] load_bytes,
    input  logic                             push,
    input  byte_t                            push_data,
    input  logic                             pop,
    output byte_t                            rd_data,
    output logic                             rd_valid,
    output logic [$clog2(DEPTH+1)-1:0]       fill
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    byte_t            mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] fill_q;
    logic             full, do_push, do_pop;

    // Accept and remove conditions; fullness is judged before any pop.
    always_comb begin
        full     = (fill_q == CNT_W'(DEPTH));
        do_push  = push && !full && !flush;
        do_pop   = pop && (fill_q != '0) && !flush;
        rd_valid = (fill_q != '0);
        rd_data  = rd_valid ? mem[rptr_q] : '0;
        fill     = fill_q;
    end

    // Storage writes: reply bytes from slot 0 on flush, else tail push.
    always_ff @(posedge clk) begin
        if (flush) begin
            for (int i = 0; i < REPLY_MAX; i++) begin
                if (i < int'(load_len)) begin
                    mem[i] <= load_bytes[i];
                end
            end
            if (push) begin
                mem[PTR_W'(load_len)] <= push_data;
            end
        end else if (do_push) begin
            mem[wptr_q] <= push_data;
        end
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else if (flush) begin
            rptr_q <= '0;
            wptr_q <= PTR_W'(load_len) + PTR_W'(push);
            fill_q <= CNT_W'(load_len) + CNT_W'(push);
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            fill_q <= fill_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/kbd_responder.sv
// Device side of a serial keyboard: key events and host commands in,
// response bytes out through a read port.
// Assumes: at most one key event and one command byte per cycle.
module kbd_responder
    import kbd_resp_pkg::*;
#(
    parameter int                                DEPTH      = 256,
    parameter int                                N_LOCKS    = 2,
    parameter logic [N_LOCKS-1:0][CODE_W-1:0]    LOCK_CODES = {7'h62, 7'h77}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] key_code,
    input  logic              key_down,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [N_LOCKS-1:0] pass_vec;
    logic               key_emit;
    byte_t              key_byte;
    reply_t             reply;
    logic               led_armed;
    logic [CNT_W-1:0]   fill;

    // One toggle filter per latching key.
    for (genvar g = 0; g < N_LOCKS; g++) begin : g_lock
        kbd_lock_filter #(.LOCK_CODE(LOCK_CODES[g])) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_valid (key_valid),
            .ev_code  (key_code),
            .ev_down  (key_down),
            .ev_pass  (pass_vec[g])
        );
    end

    // Make/break byte for the current event.
    always_comb begin
        key_emit = key_valid && (&pass_vec);
        key_byte = {~key_down, key_code};
    end

    kbd_cmd_decoder u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .reply     (reply),
        .led_armed (led_armed)
    );

    kbd_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (reply.flush),
        .load_len   (reply.len),
        .load_bytes (reply.bytes),
        .push       (key_emit),
        .push_data  (key_byte),
        .pop        (rd_en),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .fill       (fill)
    );
endmodule

// File: rtl/kbd_responder_chk.sv
// Temporal checks for kbd_responder, attached by bind.
module kbd_responder_chk #(
    parameter int                     DEPTH      = 256,
    parameter int                     N_LOCKS    = 2,
    parameter logic [N_LOCKS-1:0][6:0] LOCK_CODES = {7'h62, 7'h77}
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       key_valid,
    input logic [6:0]                 key_code,
    input logic                       key_down,
    input logic                       cmd_valid,
    input logic [7:0]                 cmd_byte,
    input logic                       rd_en,
    input logic [7:0]                 rd_data,
    input logic                       rd_valid,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic                       led_armed
);
    logic is_lock, is_known;

    // Input classification used by the properties.
    always_comb begin
        is_lock = 1'b0;
        for (int i = 0; i < N_LOCKS; i++) begin
            if (key_code == LOCK_CODES[i]) is_lock = 1'b1;
        end
        is_known = (cmd_byte == 8'h01) || (cmd_byte == 8'h07) ||
                   (cmd_byte == 8'h0E) || (cmd_byte == 8'h0F);
    end

    p_press_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && !is_lock && !rd_valid && !cmd_valid
        |=> rd_valid && rd_data == {~$past(key_down), $past(key_code)});

    p_reset_reply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !led_armed && cmd_byte == 8'h01 && !key_valid
        |=> fill == 3 && rd_data == 8'hFF);

    p_led_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        led_armed && cmd_valid |=> !led_armed);

    p_led_swallow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        led_armed && cmd_valid && !key_valid && !rd_en |=> fill == $past(fill));

    p_layout_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !led_armed && (cmd_byte == 8'h07 || cmd_byte == 8'h0F) && !key_valid
        |=> fill == 2 && rd_data == 8'hFE);

    p_other_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !led_armed && !is_known && !key_valid && !rd_en
        |=> fill == $past(fill));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH);

    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill == DEPTH && !rd_en && !cmd_valid |=> fill == DEPTH);

    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == 8'h00);

    p_reset_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_valid && !led_armed);

    p_append_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !led_armed && cmd_byte == 8'h01 && key_valid && !is_lock
        |=> fill == 4);
endmodule

bind kbd_responder kbd_responder_chk #(
    .DEPTH      (DEPTH),
    .N_LOCKS    (N_LOCKS),
    .LOCK_CODES (LOCK_CODES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .key_code  (key_code),
    .key_down  (key_down),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .fill      (fill),
    .led_armed (led_armed)
);

// File: tb/tb_kbd_responder.sv
// Self-checking bench for kbd_responder (default parameters).
module tb_kbd_responder;
    localparam int         DEPTH = 256;
    localparam logic [6:0] CAPS  = 7'h77;
    localparam logic [6:0] NUML  = 7'h62;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [6:0] key_code = '0;
    logic       key_down = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    kbd_responder dut (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .key_down(key_down), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [6:0] nl(int idx);
        int k = 0;
        for (int c = 0; c < 128; c++) begin
            if (7'(c) != CAPS && 7'(c) != NUML) begin
                if (k == idx) return 7'(c);
                k++;
            end
        end
        return 7'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic key(input logic [6:0] c, input logic dn);
        @(negedge clk);
        key_valid = 1'b1; key_code = c; key_down = dn;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Expects the head byte, then removes it.
    task automatic pop_expect(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(rd_valid && rd_data == exp, tag, {rd_valid, rd_data}, {1'b1, exp});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        check(!rd_valid && rd_data == 8'h00, tag, {rd_valid, rd_data}, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_empty("R10 reset state");

        // R9: reading an empty queue changes nothing
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        expect_empty("R9 empty read");
        key(7'h11, 1'b1);
        pop_expect(8'h11, "R9 after empty read");
        expect_empty("R9 drained");

        // R1: every non-lock code, press then release
        for (int i = 0; i < 126; i++) begin
            key(nl(i), 1'b1);
            key(nl(i), 1'b0);
        end
        for (int i = 0; i < 126; i++) begin
            pop_expect({1'b0, nl(i)}, "R1 press");
            pop_expect({1'b1, nl(i)}, "R1 release");
        end
        expect_empty("R1 drained");

        // R8: fill to capacity, one extra byte discarded
        for (int i = 0; i < DEPTH; i++) key(nl(i % 126), ((i / 126) % 2) == 0);
        key(nl(5), 1'b1);
        for (int i = 0; i < DEPTH; i++)
            pop_expect({((i / 126) % 2) != 0, nl(i % 126)}, "R8 full order");
        expect_empty("R8 extra discarded");

        // R2: lock filter sequence on caps
        key(CAPS, 1'b1); key(CAPS, 1'b0); key(CAPS, 1'b1); key(CAPS, 1'b0);
        pop_expect({1'b0, CAPS}, "R2 first press");
        pop_expect({1'b1, CAPS}, "R2 second release");
        expect_empty("R2 others dropped");

        // R3: interleaved lock keys stay independent
        key(CAPS, 1'b1); key(NUML, 1'b1); key(CAPS, 1'b0); key(NUML, 1'b0);
        key(NUML, 1'b1); key(CAPS, 1'b1); key(NUML, 1'b0); key(CAPS, 1'b0);
        pop_expect({1'b0, CAPS}, "R3 caps press");
        pop_expect({1'b0, NUML}, "R3 num press");
        pop_expect({1'b1, NUML}, "R3 num release");
        pop_expect({1'b1, CAPS}, "R3 caps release");
        expect_empty("R3 drained");

        // R4: reset command flushes and replies
        key(7'h0A, 1'b1); key(7'h0B, 1'b0);
        cmd(8'h01);
        pop_expect(8'hFF, "R4 byte0");
        pop_expect(8'h04, "R4 byte1");
        pop_expect(8'h7F, "R4 byte2");
        expect_empty("R4 length");

        // R6: both layout queries
        key(7'h0C, 1'b1);
        cmd(8'h07);
        cmd(8'h0F);
        pop_expect(8'hFE, "R6 byte0");
        pop_expect(8'h21, "R6 byte1");
        expect_empty("R6 length");

        // R5: byte after indicator command is swallowed
        key(7'h14, 1'b1);
        cmd(8'h0E); cmd(8'h01);
        pop_expect(8'h14, "R5 swallowed reset");
        expect_empty("R5 no reply");
        cmd(8'h0E); cmd(8'h0E); cmd(8'h0F);
        pop_expect(8'hFE, "R5 flag cleared");
        pop_expect(8'h21, "R5 flag cleared");
        expect_empty("R5 drained");

        // R7: every other command byte ignored
        key(7'h1E, 1'b0);
        for (int b = 0; b < 256; b++) begin
            if (b != 8'h01 && b != 8'h07 && b != 8'h0E && b != 8'h0F) cmd(8'(b));
        end
        pop_expect(8'h9E, "R7 queue intact");
        expect_empty("R7 nothing added");

        // R11: key event in the same cycle as a layout query
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h07;
        key_valid = 1'b1; key_code = 7'h28; key_down = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; key_valid = 1'b0;
        pop_expect(8'hFE, "R11 reply0");
        pop_expect(8'h21, "R11 reply1");
        pop_expect(8'h28, "R11 key after reply");
        expect_empty("R11 drained");

        // R10: reset clears lock state, indicator flag and queue
        key(CAPS, 1'b1); key(CAPS, 1'b0);
        pop_expect({1'b0, CAPS}, "R10 setup");
        cmd(8'h0E);
        key(7'h32, 1'b1);
        do_reset();
        expect_empty("R10 queue cleared");
        key(CAPS, 1'b1);
        pop_expect({1'b0, CAPS}, "R10 lock cleared");
        cmd(8'h07);
        pop_expect(8'hFE, "R10 flag cleared");
        pop_expect(8'h21, "R10 flag cleared");
        expect_empty("R10 drained");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule